// File: doc/BRIEF.md
# Local Interrupt Aggregator With Write-One-To-Clear Acknowledge

This block collects interrupt causes on the local side of a bus bridge. Each local event source delivers a single-cycle pulse. The pulse sets a sticky status bit. The local interrupt request, which is active low, is held asserted while any status bit is set and its enable bit is also set. Local software acknowledges an event by writing a 1 to the matching status bit. Writing a 0 to a status bit leaves it unchanged.

A second path carries an external interrupt line, which is active low and level sensitive. Several open-drain sources may share this line. The line passes through a two-flop synchronizer and is gated by a single control bit. The result drives an active-low host interrupt output. This path has no latch. The host output follows the synchronized input level and releases only when the far side removes the source.

Both paths are controlled through a small register port with two word addresses: status and control.

Top module: `lirq_hub`

## Requirements
- R1: After reset all status bits and control bits read as 0, and `local_irq_n` and `host_irq_n` are both 1.
- R2: A 1 on `evt_pulse[i]` at a rising clock edge sets status bit i at that edge. The bit stays set after the pulse ends, until it is cleared.
- R3: A write to address 0 (status) clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If an event pulse and a clearing write hit the same status bit at the same edge, the bit stays set.
- R5: `local_irq_n` is 0 exactly when some status bit i and enable bit i are both 1. Enable bits are control bits [N_SRC-1:0]. The output changes in the same cycle as the register change.
- R6: A status bit is set even while its enable bit is 0. Setting the enable bit later asserts `local_irq_n`.
- R7: A write to address 1 (control) stores data bits [N_SRC-1:0] as the enables and data bit EXT_EN_BIT (13 by default) as the external-path enable. Other bits are ignored.
- R8: Reads are combinational. Address 0 returns the status bits in [N_SRC-1:0]. Address 1 returns the enables and the external-path enable in bit EXT_EN_BIT. All other bits read as 0.
- R9: With the external-path enable at 1, a 0 on `ext_irq_n` drives `host_irq_n` to 0 at the second rising edge after the input changes. A return of the input to 1 releases the output with the same two-edge latency.
- R10: With the external-path enable at 0, `host_irq_n` stays 1 whatever `ext_irq_n` does.
- R11: A write to the control register leaves the status bits unchanged. A write to the status register has no effect on `host_irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | N_SRC | One-cycle event pulses from the local sources |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Register select: 0 selects status, 1 selects control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register selected by `reg_addr` |
| ext_irq_n | input | 1 | External level interrupt, active low, asynchronous |
| local_irq_n | output | 1 | Local interrupt request, active low |
| host_irq_n | output | 1 | Host interrupt, active low |

## Verification
The bench builds the block with N_SRC = 5 and leaves EXT_EN_BIT at its default of 13. Five sources make it possible to test collisions and partial clears on a bit above the lowest byte nibble. Bits 5 to 12 and 14 to 31 then show that only the defined fields are stored and read back. The external path is tested at the exact edge where the synchronizer output changes, with the enable both set and cleared. This lets the bench confirm the two-edge latency and that no clearing write can release the host output.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned REG_W = 32;

  // Next value of a sticky status vector: clear requested bits, then let
  // events win over the clear.
  function automatic logic [REG_W-1:0] sticky_next(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] evt,
    input logic [REG_W-1:0] clr
  );
    return (cur & ~clr) | evt;
  endfunction

  // Any pending and enabled cause.
  function automatic logic pending_any(
    input logic [REG_W-1:0] stat,
    input logic [REG_W-1:0] en
  );
    return |(stat & en);
  endfunction
endpackage

// File: rtl/lirq_status.sv
module lirq_status #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] stat_q
);
  import lirq_pkg::*;

  logic [REG_W-1:0] nxt_full;

  always_comb begin
    nxt_full = sticky_next(REG_W'(stat_q), REG_W'(evt), REG_W'(clr_mask));
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[g] <= 1'b0;
      else        stat_q[g] <= nxt_full[g];
    end
  end
endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl #(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned EXT_EN_BIT = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  output logic [N_SRC-1:0] en_q,
  output logic             ext_en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      ext_en_q <= 1'b0;
    end else if (wr) begin
      en_q     <= wdata[N_SRC-1:0];
      ext_en_q <= wdata[EXT_EN_BIT];
    end
  end
endmodule

// File: rtl/lirq_ext_sync.sv
module lirq_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_irq_n,
  input  logic ext_en,
  output logic ext_seen,
  output logic host_irq_n
);
  logic [STAGES-1:0] chain_n;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_n[0] <= 1'b1;
        else        chain_n[0] <= ext_irq_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_n[s] <= 1'b1;
        else        chain_n[s] <= chain_n[s-1];
      end
    end
  end

  assign ext_seen   = ~chain_n[STAGES-1];
  assign host_irq_n = ~(ext_seen & ext_en);
endmodule

// File: rtl/lirq_hub.sv
module lirq_hub #(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned EXT_EN_BIT = 13,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_pulse,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ext_irq_n,
  output logic             local_irq_n,
  output logic             host_irq_n
);
  import lirq_pkg::*;

  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  // Named internal events, visible to the checker.
  logic             wr_stat;
  logic             wr_ctrl;
  logic [N_SRC-1:0] w1c_mask;
  logic [N_SRC-1:0] stat_q;
  logic [N_SRC-1:0] en_q;
  logic             ext_en;
  logic             ext_seen;
  logic             local_req;

  assign wr_stat  = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign w1c_mask = wr_stat ? reg_wdata[N_SRC-1:0] : '0;

  lirq_status #(.N_SRC(N_SRC)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .clr_mask (w1c_mask),
    .stat_q   (stat_q)
  );

  lirq_ctrl #(.N_SRC(N_SRC), .EXT_EN_BIT(EXT_EN_BIT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_ctrl),
    .wdata    (reg_wdata),
    .en_q     (en_q),
    .ext_en_q (ext_en)
  );

  lirq_ext_sync #(.STAGES(SYNC_DEPTH)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_irq_n  (ext_irq_n),
    .ext_en     (ext_en),
    .ext_seen   (ext_seen),
    .host_irq_n (host_irq_n)
  );

  assign local_req   = pending_any(REG_W'(stat_q), REG_W'(en_q));
  assign local_irq_n = ~local_req;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STAT) begin
      reg_rdata[N_SRC-1:0] = stat_q;
    end else begin
      reg_rdata[N_SRC-1:0]   = en_q;
      reg_rdata[EXT_EN_BIT]  = ext_en;
    end
  end
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk #(
  parameter int unsigned N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_pulse,
  input logic [N_SRC-1:0] w1c_mask,
  input logic [N_SRC-1:0] stat_q,
  input logic [N_SRC-1:0] en_q,
  input logic             ext_en,
  input logic             wr_ctrl,
  input logic             ext_irq_n,
  input logic             local_irq_n,
  input logic             host_irq_n
);
  // R2 and R4: every pulsed bit is set one edge later, clear or not.
  a_r2_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R3: a written 1 without a colliding event clears the bit.
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(w1c_mask & ~evt_pulse)) |=> ((stat_q & $past(w1c_mask & ~evt_pulse)) == '0));

  // R3: bits not cleared never drop.
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(w1c_mask)) & ~stat_q) == '0));

  // R5: a low request needs a pending enabled bit.
  a_r5_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    !local_irq_n |-> (|stat_q) && (|en_q));

  // R9: a low host output needs the input low two edges back.
  a_r9_ext_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !host_irq_n |-> !$past(ext_irq_n, 2));

  // R10: disabled path keeps the host output high.
  a_r10_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> host_irq_n);

  // R11: control writes leave status alone when no event or clear occurs.
  a_r11_ctrl_keeps_stat: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && evt_pulse == '0) |=> $stable(stat_q));
endmodule

bind lirq_hub lirq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_pulse   (evt_pulse),
  .w1c_mask    (w1c_mask),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .ext_en      (ext_en),
  .wr_ctrl     (wr_ctrl),
  .ext_irq_n   (ext_irq_n),
  .local_irq_n (local_irq_n),
  .host_irq_n  (host_irq_n)
);

// File: tb/sim_lirq_hub.sv
`timescale 1ns/1ps
module sim_lirq_hub;
  localparam int unsigned N = 5;
  localparam int unsigned XB = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_pulse = '0;
  logic          reg_wr = 1'b0;
  logic          reg_addr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ext_irq_n = 1'b1;
  logic          local_irq_n;
  logic          host_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lirq_hub #(.N_SRC(N), .EXT_EN_BIT(XB)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_irq_n(ext_irq_n), .local_irq_n(local_irq_n), .host_irq_n(host_irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge; the rising edge acts; return on the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic a, output logic [31:0] d);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    evt_pulse = m;
    step();
    evt_pulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(1'b0, d); chk("R1 status", d, 32'h0);
    rd_reg(1'b1, d); chk("R1 control", d, 32'h0);
    chk("R1 local_irq_n", local_irq_n, 1);
    chk("R1 host_irq_n", host_irq_n, 1);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(5'b00101);
    step(); step();
    rd_reg(1'b0, d); chk("R2 sticky bits", d, 32'h05);
    chk("R6 disabled no request", local_irq_n, 1);
    wr_reg(1'b1, 32'h0000_0004);
    chk("R6 enable later asserts", local_irq_n, 0);
    rd_reg(1'b0, d); chk("R11 control write keeps status", d, 32'h05);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr_reg(1'b0, 32'h0000_0001);
    rd_reg(1'b0, d); chk("R3 clear bit0 only", d, 32'h04);
    chk("R5 still pending bit2", local_irq_n, 0);
    wr_reg(1'b0, 32'h0);
    rd_reg(1'b0, d); chk("R3 zero write no effect", d, 32'h04);
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, d); chk("R3 clear all", d, 32'h0);
    chk("R5 request released", local_irq_n, 1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(5'b10000);
    evt_pulse = 5'b10000;
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h10;
    step();
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd_reg(1'b0, d); chk("R4 event wins over clear", d, 32'h10);
    wr_reg(1'b1, 32'h0000_0010);
    chk("R5 bit4 enabled request", local_irq_n, 0);
    wr_reg(1'b0, 32'h10);
    chk("R5 request off after clear", local_irq_n, 1);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr_reg(1'b1, 32'hFFFF_FFFF);
    rd_reg(1'b1, d); chk("R7 R8 control fields only", d, 32'h0000_201F);
    rd_reg(1'b0, d); chk("R8 status upper bits zero", d, 32'h0);
    wr_reg(1'b1, 32'h0000_0000);
    rd_reg(1'b1, d); chk("R7 control cleared", d, 32'h0);
  endtask

  task automatic t_ext_enabled();
    wr_reg(1'b1, 32'h0000_2000);
    ext_irq_n = 1'b0;
    step();
    chk("R9 not yet after one edge", host_irq_n, 1);
    step();
    chk("R9 asserted after two edges", host_irq_n, 0);
    wr_reg(1'b0, 32'hFFFF_FFFF);
    chk("R11 status write keeps host", host_irq_n, 0);
    ext_irq_n = 1'b1;
    step();
    chk("R9 held one edge after release", host_irq_n, 0);
    step();
    chk("R9 released after two edges", host_irq_n, 1);
  endtask

  task automatic t_ext_disabled();
    wr_reg(1'b1, 32'h0);
    ext_irq_n = 1'b0;
    step(); step(); step();
    chk("R10 disabled stays high", host_irq_n, 1);
    wr_reg(1'b1, 32'h0000_2000);
    chk("R9 enable with input held low", host_irq_n, 0);
    ext_irq_n = 1'b1;
    step(); step();
    chk("R9 released", host_irq_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_w1c();
    t_collide();
    t_readback();
    t_ext_enabled();
    t_ext_disabled();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule